// File: doc/BRIEF.md
# Serial Programming Byte Readback Engine

This engine sits on the host side of a two-wire serial programming link made of a clock line and a shared data line. A single start request makes it run one readback transaction. It shifts a fixed 4-bit "send latch byte" command to the target. It holds the clock low for an extra half period. It then runs a 16-clock operand phase. In the first eight clocks of that phase the host drives zeros. In the last eight clocks the host lets go of the data line and collects the byte the target shifts out.

The serial clock comes from the system clock. Each half period lasts `half_div_i + 1` system cycles, and that value is latched when the transaction starts. The engine drives the data line through a separate output-enable pin, so the pad level outside the block can build the tristate buffer. It reports the result on `rd_byte_o` together with a one-cycle `done_o` pulse. `busy_o` stays high for the whole transaction.

Top module: `twr_rdback_top`

## Requirements
- R1: During reset and after it: `sclk_o`=0, `sdat_oe_o`=1, `sdat_o`=0, `busy_o`=0, `done_o`=0, `rd_byte_o`=0.
- R2: The command phase has 4 serial clocks. Each clock is a high half followed by a low half, and each half lasts `half_div_i+1` system cycles. The command code is 4'b0010. It is sent bit 0 first, and each bit is placed on `sdat_o` when the clock goes high.
- R3: After the low half of the fourth command clock, `sclk_o` stays low for one more half period before the operand phase starts.
- R4: The operand phase has 16 serial clocks. During its first 8 clocks the host drives `sdat_o`=0 with `sdat_oe_o`=1.
- R5: `sdat_oe_o` goes low when the clock goes high for operand clock 9. It stays low until the transaction ends, and it returns high together with `done_o`.
- R6: `sdat_i` is sampled at the falling edge of operand clocks 9 to 16. The first sample becomes bit 0 of the result and the last becomes bit 7.
- R7: `busy_o` is high from the cycle after an accepted start through the last half period, 41 half periods in all. `done_o` is high for exactly one cycle, the cycle right after that, while `busy_o` is low.
- R8: `start_i` is accepted only while `busy_o` is low, and that includes the `done_o` cycle. A start while busy changes nothing.
- R9: `rd_byte_o` changes only in the `done_o` cycle. At all other times it holds the last result.
- R10: `half_div_i` is latched when a start is accepted. Changing it during a transaction does not affect that transaction's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one readback transaction |
| half_div_i | input | DIV_W | Serial half period, minus one, in system cycles |
| sdat_i | input | 1 | Data line level seen from the pad |
| sclk_o | output | 1 | Serial programming clock |
| sdat_o | output | 1 | Data value driven by the host |
| sdat_oe_o | output | 1 | High when the host drives the data line |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_byte_o | output | BYTE_W | Byte captured by the last transaction |

## Verification
A wrong phase or a wrong bit count changes the serial clock pattern or the output-enable pattern within one half period. The bench compares both against a reference built from elapsed cycles, so the divergence shows up in the first cycle it happens. A mistake in the sampling edge or the bit order does not show until `done_o`, when the captured byte differs from the byte the bench target model sent. Using several distinct byte patterns makes an order swap or an off-by-one sample visible. A released line that comes back too early or too late shows up as an output-enable mismatch in that same cycle.

// File: rtl/twr_rdback_pkg.sv
package twr_rdback_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_GAP  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;
endpackage

// File: rtl/twr_half_timer.sv
module twr_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = !clr_i && (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: the counter never runs past the latched limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> cnt_q <= limit_i);
endmodule

// File: rtl/twr_rdback_top.sv
module twr_rdback_top
    import twr_rdback_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter int          BYTE_W    = 8,
    parameter int          CMD_BITS  = 4,
    parameter int          DATA_CLKS = 16,
    parameter logic [3:0]  CMD_CODE  = 4'b0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic              sdat_i,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              sdat_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rd_byte_o
);
    localparam int CNT_W = $clog2(DATA_CLKS);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_CLKS - 1);
    localparam logic [CNT_W-1:0] CAPT_FROM = CNT_W'(DATA_CLKS - BYTE_W);

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic                sclk;
        logic                dout;
        logic                oe;
        logic                done;
        logic [CMD_BITS-1:0] cmd;
        logic [DIV_W-1:0]    div;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   rbyte;
    } st_t;

    st_t  s_d, s_q;
    logic tick;

    twr_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (s_q.ph == PH_IDLE),
        .limit_i(s_q.div),
        .tick_o (tick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph   = PH_CMD;
                    s_d.cnt  = '0;
                    s_d.sclk = 1'b1;
                    s_d.cmd  = CMD_CODE[CMD_BITS-1:0];
                    s_d.dout = CMD_CODE[0];
                    s_d.oe   = 1'b1;
                    s_d.div  = half_div_i;
                end
            end
            PH_CMD: begin
                if (tick) begin
                    if (s_q.sclk) begin
                        s_d.sclk = 1'b0;
                    end else if (s_q.cnt == LAST_CMD) begin
                        s_d.ph   = PH_GAP;
                        s_d.dout = 1'b0;
                    end else begin
                        s_d.cnt  = s_q.cnt + CNT_W'(1);
                        s_d.cmd  = s_q.cmd >> 1;
                        s_d.dout = s_q.cmd[1];
                        s_d.sclk = 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    s_d.ph   = PH_DATA;
                    s_d.cnt  = '0;
                    s_d.sclk = 1'b1;
                    s_d.dout = 1'b0;
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (s_q.sclk) begin
                        s_d.sclk = 1'b0;
                        if (s_q.cnt >= CAPT_FROM)
                            s_d.shreg = {sdat_i, s_q.shreg[BYTE_W-1:1]};
                    end else if (s_q.cnt == LAST_DATA) begin
                        s_d.ph    = PH_IDLE;
                        s_d.done  = 1'b1;
                        s_d.oe    = 1'b1;
                        s_d.rbyte = s_q.shreg;
                    end else begin
                        s_d.cnt  = s_q.cnt + CNT_W'(1);
                        s_d.sclk = 1'b1;
                        if (s_q.cnt + CNT_W'(1) >= CAPT_FROM) s_d.oe = 1'b0;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_IDLE;
            s_q.oe   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o    = s_q.sclk;
    assign sdat_o    = s_q.dout;
    assign sdat_oe_o = s_q.oe;
    assign busy_o    = (s_q.ph != PH_IDLE);
    assign done_o    = s_q.done;
    assign rd_byte_o = s_q.rbyte;

    // R7: completion pulse never overlaps busy and lasts one cycle
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: the line is only released inside a transaction
    a_r5_release_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        !sdat_oe_o |-> busy_o);
    // R9: the result moves only with the completion pulse
    a_r9_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (!done_o |-> $stable(rd_byte_o)));
    // R2: the serial clock moves only on a half-period tick or at start
    a_r2_clk_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick) |=> $stable(sclk_o));
    // R3: the gap keeps the clock low
    a_r3_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GAP) |-> !sclk_o);
    // R4: host drives only zeros while it owns the line in the operand phase
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_DATA && sdat_oe_o) |-> !sdat_o);
endmodule

// File: tb/twr_rdback_top_tb.sv
module twr_rdback_top_tb_top;
    localparam int CLK_P  = 10;
    localparam int NHALF  = 41;
    localparam logic [3:0] CMD = 4'b0010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] half_div_i = 8'd0;
    logic       sdat_i;
    logic       sclk_o, sdat_o, sdat_oe_o, busy_o, done_o;
    logic [7:0] rd_byte_o;

    int tests = 0;
    int fails = 0;

    // reference model state
    int         e_m = -1;
    int         h_m = 1;
    logic [7:0] tgt_byte = 8'h00;
    logic [7:0] exp_byte = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    twr_rdback_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_div_i(half_div_i),
        .sdat_i(sdat_i), .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o),
        .busy_o(busy_o), .done_o(done_o), .rd_byte_o(rd_byte_o)
    );

    // R8, R10: start taken only when idle or in the completion cycle; divider latched
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_m <= -1;
        end else if ((e_m < 0 || e_m == NHALF*h_m) && start_i) begin
            e_m <= 0;
            h_m <= int'(half_div_i) + 1;
        end else if (e_m >= 0 && e_m < NHALF*h_m) begin
            e_m <= e_m + 1;
            if (e_m + 1 == NHALF*h_m) exp_byte <= tgt_byte;
        end else if (e_m == NHALF*h_m) begin
            e_m <= -1;
        end
    end

    // target model: drives byte bit k during operand clock 9+k, else pulled high
    always_comb begin
        sdat_i = 1'b1;
        if (e_m >= 0 && e_m < NHALF*h_m && e_m / h_m >= 9) begin
            if ((e_m / h_m - 9) / 2 >= 8)
                sdat_i = tgt_byte[(e_m / h_m - 9) / 2 - 8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic xp_clk, xp_oe, xp_dout, xp_busy, xp_done;
            int   hi;
            xp_clk = 0; xp_oe = 1; xp_dout = 0; xp_busy = 0; xp_done = 0;
            if (e_m >= 0 && e_m < NHALF*h_m) begin
                hi = e_m / h_m;
                xp_busy = 1;
                if (hi < 8) begin
                    xp_clk  = (hi % 2 == 0);
                    xp_dout = CMD[hi/2];
                end else if (hi == 8) begin
                    xp_clk = 0;
                end else begin
                    xp_clk = ((hi - 9) % 2 == 0);
                    xp_oe  = ((hi - 9) / 2 < 8);
                end
            end else if (e_m == NHALF*h_m) begin
                xp_done = 1;
            end
            chk(sclk_o == xp_clk,     "R2/R3", "sclk",  sclk_o,    xp_clk);
            chk(sdat_oe_o == xp_oe,   "R5",    "oe",    sdat_oe_o, xp_oe);
            chk(sdat_o == xp_dout,    "R2/R4", "sdat",  sdat_o,    xp_dout);
            chk(busy_o == xp_busy,    "R7/R8", "busy",  busy_o,    xp_busy);
            chk(done_o == xp_done,    "R7",    "done",  done_o,    xp_done);
            chk(rd_byte_o == exp_byte,"R6/R9", "byte",  rd_byte_o, exp_byte);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (e_m >= 0) @(negedge clk);
    endtask

    task automatic run(input logic [7:0] div, input logic [7:0] b);
        @(negedge clk);
        half_div_i = div;
        tgt_byte   = b;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        wait_idle();
    endtask

    initial begin
        #(CLK_P*200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(sclk_o == 0 && sdat_oe_o == 1 && sdat_o == 0, "R1", "pins", {sclk_o, sdat_oe_o, sdat_o}, 3'b010);
        chk(busy_o == 0 && done_o == 0, "R1", "status", {busy_o, done_o}, 0);
        chk(rd_byte_o == 8'h00, "R1", "byte", rd_byte_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R6: fastest clock and several byte patterns
        run(8'd0, 8'hA5);
        run(8'd2, 8'h00);
        run(8'd1, 8'hFF);
        run(8'd5, 8'h81);

        // R8, R10: start and divider changes while busy are ignored
        @(negedge clk);
        half_div_i = 8'd3; tgt_byte = 8'h3C; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        half_div_i = 8'd0; start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        // R8: start held into the completion cycle begins the next transaction
        @(negedge clk);
        half_div_i = 8'd1; tgt_byte = 8'h6E; start_i = 1'b1;
        @(negedge clk);
        while (!(e_m == NHALF*h_m)) @(negedge clk);
        tgt_byte = 8'h17;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        // R9: byte holds while idle
        repeat (10) @(negedge clk);
        chk(rd_byte_o == 8'h17, "R9", "idle hold", rd_byte_o, 8'h17);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule